// File: doc/BRIEF.md
# Register-Programmed Strobe Divider with Stop

This block derives a slower timing strobe from one of several parent timing strobes, all living in a single system clock domain. Each parent is a one-cycle clock-enable pulse. The block picks one parent and divides its pulse rate by an integer from 1 to 64. It drives two outputs: a divided one-cycle strobe, and a square wave that flips on every divided strobe, so it runs at half the strobe rate.

A single 32-bit control word, written and read through a plain write-enable/data port, sets the block up. The word holds a run/stop flag, a divide field and, when the block has more than one parent, a parent-select field. The compile-time parent count (1, 4 or 8) sets where the select field sits.

A new divisor or parent written while the block runs takes effect only at the end of the current output period. No output period is ever cut short or stretched.

Top module: `ratediv_top`

## Requirements
- R1: Bits 5:0 of the control word hold the divide field F. When the block runs, exactly one output strobe (out_stb high for one cycle) is produced for every F+1 strobes of the selected parent. out_stb rises in the cycle after the parent strobe that completes the period. F = 0 passes every selected strobe, and F = 63 divides by 64.
- R2: Bit 8 is the stop flag. While it is stored as 1, out_stb stays low and out_sq holds its value, whatever the parent strobes do.
- R3: The parent is chosen by bits 14:12 when NUM_PAR is 8, and by bits 7:6 when NUM_PAR is 4. When NUM_PAR is 1 there is no select field and parent 0 is always used. Strobes on parents that are not selected are not counted.
- R4: A write with bit 8 set and bits 5:0 all zero stores 63 in the divide field. A write with bit 8 set and a non-zero divide field stores that field unchanged.
- R5: A read returns the stored stop flag, the select field (in its configured position) and the divide field. Every other bit reads as 0, including the select bits of a configuration that has no such field.
- R6: A divisor or select value written while a period is in progress applies only after that period completes. Strobes of the previously selected parent finish the old period at the old ratio.
- R7: When the stop flag is cleared, counting restarts from zero. The first output strobe follows F+1 selected-parent strobes, whatever count existed before the stop.
- R8: out_sq inverts in the same cycle that out_stb is high, and at no other time.
- R9: Synchronous active-high reset leaves the control word reading 0x0000013F (stopped, F = 63, select 0), with out_stb and out_sq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Stored control word |
| par_stb | input | NUM_PAR | Parent timing strobes, one per parent |
| out_stb | output | 1 | Divided one-cycle output strobe |
| out_sq | output | 1 | Square wave toggled by each output strobe |

## Verification
The bench builds three instances side by side, with NUM_PAR set to 8, 4 and 1. The 8-parent instance carries most scenarios: divide ratios 1, 3, 4 and 64, stop and restart, and mid-period changes of both divisor and parent. The 4-parent and 1-parent instances show where the select field sits and that it reads back as zero when absent. They also show that only the configured parent's strobes count.

// File: rtl/ratediv_pkg.sv
package ratediv_pkg;

    localparam int CTL_W     = 32;
    localparam int DIV_W     = 6;
    localparam int SEL_W_MAX = 3;
    localparam int STOP_POS  = 8;

    typedef logic [DIV_W-1:0]     div_t;
    typedef logic [SEL_W_MAX-1:0] sel_t;
    typedef logic [CTL_W-1:0]     word_t;

    typedef struct packed {
        logic stop;
        sel_t sel;
        div_t div;
    } ctl_t;

    // width of the select field for a given parent count
    function automatic int sel_width(input int npar);
        if (npar == 8) return 3;
        if (npar == 4) return 2;
        return 1;
    endfunction

    // word image of a stored control value
    function automatic word_t pack_ctl(input ctl_t c, input int npar);
        word_t w;
        w = '0;
        w[DIV_W-1:0] = c.div;
        w[STOP_POS]  = c.stop;
        if (npar == 4) w[7:6]   = c.sel[1:0];
        if (npar == 8) w[14:12] = c.sel;
        return w;
    endfunction

    // control value captured from a written word, with stop fix-up
    function automatic ctl_t unpack_write(input word_t w, input int npar);
        ctl_t c;
        c.div  = w[DIV_W-1:0];
        c.stop = w[STOP_POS];
        c.sel  = '0;
        if (npar == 4) c.sel = {1'b0, w[7:6]};
        if (npar == 8) c.sel = w[14:12];
        if (c.stop && (c.div == '0)) c.div = '1;
        return c;
    endfunction

    // bits that can read back non-zero
    function automatic word_t live_mask(input int npar);
        ctl_t all;
        all.stop = 1'b1;
        all.sel  = '1;
        all.div  = '1;
        return pack_ctl(all, npar);
    endfunction

endpackage

// File: rtl/ratediv_reg.sv
module ratediv_reg
    import ratediv_pkg::*;
#(
    parameter int NUM_PAR = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_data,
    output ctl_t  ctl,
    output word_t rd_data
);

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.stop <= 1'b1;
            ctl_q.sel  <= '0;
            ctl_q.div  <= '1;
        end else if (wr_en) begin
            ctl_q <= unpack_write(wr_data, NUM_PAR);
        end
    end

    assign ctl     = ctl_q;
    assign rd_data = pack_ctl(ctl_q, NUM_PAR);

endmodule

// File: rtl/ratediv_pick.sv
module ratediv_pick
    import ratediv_pkg::*;
#(
    parameter int NUM_PAR = 8
) (
    input  logic [NUM_PAR-1:0] par_stb,
    input  sel_t               sel,
    output logic               stb
);

    localparam int SW = sel_width(NUM_PAR);

    generate
        if (NUM_PAR == 1) begin : g_single
            logic unused_sel;
            assign unused_sel = ^sel;
            assign stb = par_stb[0];
        end else begin : g_multi
            logic [SW-1:0] idx;
            logic          unused_hi;
            assign idx       = sel[SW-1:0];
            assign unused_hi = ^sel;
            assign stb       = par_stb[idx];
        end
    endgenerate

endmodule

// File: rtl/ratediv_cnt.sv
module ratediv_cnt
    import ratediv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic sel_stb,
    output sel_t eff_sel,
    output logic out_stb,
    output logic out_sq
);

    div_t cnt;
    div_t act_div;
    sel_t act_sel;
    logic open_q;
    div_t eff_div;

    // a period is open once its first strobe is counted
    assign open_q  = (cnt != '0);
    assign eff_div = open_q ? act_div : ctl.div;
    assign eff_sel = open_q ? act_sel : ctl.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_div <= '0;
            act_sel <= '0;
            out_stb <= 1'b0;
            out_sq  <= 1'b0;
        end else if (ctl.stop) begin
            cnt     <= '0;
            out_stb <= 1'b0;
        end else begin
            out_stb <= 1'b0;
            if (sel_stb) begin
                if (cnt == eff_div) begin
                    cnt     <= '0;
                    out_stb <= 1'b1;
                    out_sq  <= ~out_sq;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (!open_q) begin
                        act_div <= ctl.div;
                        act_sel <= ctl.sel;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ratediv_top.sv
module ratediv_top
    import ratediv_pkg::*;
#(
    parameter int NUM_PAR = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [NUM_PAR-1:0] par_stb,
    output logic               out_stb,
    output logic               out_sq
);

    ctl_t ctl;
    sel_t eff_sel;
    logic sel_stb;

    ratediv_reg #(.NUM_PAR(NUM_PAR)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl),
        .rd_data (rd_data)
    );

    ratediv_pick #(.NUM_PAR(NUM_PAR)) u_pick (
        .par_stb (par_stb),
        .sel     (eff_sel),
        .stb     (sel_stb)
    );

    ratediv_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .sel_stb (sel_stb),
        .eff_sel (eff_sel),
        .out_stb (out_stb),
        .out_sq  (out_sq)
    );

endmodule

// File: rtl/ratediv_chk.sv
module ratediv_chk
    import ratediv_pkg::*;
#(
    parameter int NUM_PAR = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [31:0]        rd_data,
    input logic [NUM_PAR-1:0] par_stb,
    input logic               out_stb,
    input logic               out_sq
);

    localparam word_t LIVE = live_mask(NUM_PAR);

    // R2: stopped means no output strobe
    a_r2_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        rd_data[STOP_POS] |=> !out_stb);

    // R2: stopped means square output holds
    a_r2_stop_hold: assert property (@(posedge clk) disable iff (rst)
        rd_data[STOP_POS] |=> $stable(out_sq));

    // R4: a stored stop never pairs with a zero divide field
    a_r4_stop_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        rd_data[STOP_POS] |-> (rd_data[DIV_W-1:0] != '0));

    // R5: bits outside the live fields read zero
    a_r5_dead_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE) == '0);

    // R1: an output strobe follows a parent strobe
    a_r1_stb_has_parent: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> $past(|par_stb));

    // R8: square output flips with each output strobe
    a_r8_flip_on_stb: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> (out_sq != $past(out_sq)));

    // R8: square output flips only with an output strobe
    a_r8_flip_only_stb: assert property (@(posedge clk) disable iff (rst)
        (out_sq != $past(out_sq)) |-> out_stb);

endmodule

bind ratediv_top ratediv_chk #(.NUM_PAR(NUM_PAR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_data (rd_data),
    .par_stb (par_stb),
    .out_stb (out_stb),
    .out_sq  (out_sq)
);

// File: tb/ratediv_top_tb.sv
`timescale 1ns/1ps
module ratediv_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we8 = 1'b0, we4 = 1'b0, we1 = 1'b0;
    logic [31:0] wd  = '0;
    logic [7:0]  ps  = '0;
    logic [31:0] rd8, rd4, rd1;
    logic        o8, o4, o1, q8, q4, q1;
    logic        s8, s4, s1;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    ratediv_top #(.NUM_PAR(8)) u_dut (
        .clk(clk), .rst(rst), .wr_en(we8), .wr_data(wd), .rd_data(rd8),
        .par_stb(ps), .out_stb(o8), .out_sq(q8));

    ratediv_top #(.NUM_PAR(4)) u_dut4 (
        .clk(clk), .rst(rst), .wr_en(we4), .wr_data(wd), .rd_data(rd4),
        .par_stb(ps[3:0]), .out_stb(o4), .out_sq(q4));

    ratediv_top #(.NUM_PAR(1)) u_dut1 (
        .clk(clk), .rst(rst), .wr_en(we1), .wr_data(wd), .rd_data(rd1),
        .par_stb(ps[0]), .out_stb(o1), .out_sq(q1));

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] who, input logic [31:0] d);
        @(negedge clk);
        {we8, we4, we1} = who;
        wd = d;
        @(negedge clk);
        {we8, we4, we1} = 3'b000;
    endtask

    // one parent strobe pulse; outputs sampled the cycle after
    task automatic strobe(input logic [7:0] m);
        @(negedge clk);
        ps = m;
        @(negedge clk);
        ps = '0;
        s8 = o8; s4 = o4; s1 = o1;
    endtask

    task automatic t_reset;
        chk(rd8 == 32'h13F, "R9 reset word u_dut", rd8, 32'h13F);
        chk(rd4 == 32'h13F, "R9 reset word u_dut4", rd4, 32'h13F);
        chk(rd1 == 32'h13F, "R9 reset word u_dut1", rd1, 32'h13F);
        chk(!o8 && !q8, "R9 reset outputs low", {o8, q8}, 0);
        strobe(8'hFF);
        chk(!s8 && !s4 && !s1, "R2 no strobe while stopped", {s8, s4, s1}, 0);
    endtask

    task automatic t_readback;
        wr(3'b111, 32'hFFFF_FEFF);
        chk(rd8 == 32'h703F, "R5 readback 8 parents", rd8, 32'h703F);
        chk(rd4 == 32'h00FF, "R5 readback 4 parents", rd4, 32'h00FF);
        chk(rd1 == 32'h003F, "R5 readback 1 parent", rd1, 32'h003F);
        wr(3'b111, 32'h0000_0100);
        chk(rd8 == 32'h13F, "R4 stop with zero field", rd8, 32'h13F);
        chk(rd4 == 32'h13F, "R4 stop with zero field u_dut4", rd4, 32'h13F);
        wr(3'b100, 32'h0000_0105);
        chk(rd8 == 32'h105, "R4 stop keeps nonzero field", rd8, 32'h105);
    endtask

    task automatic t_divide3;
        logic sq0;
        wr(3'b100, 32'h0000_2002);
        chk(rd8 == 32'h2002, "R5 select and divide stored", rd8, 32'h2002);
        strobe(8'h01);
        chk(!s8, "R3 unselected parent ignored", s8, 0);
        sq0 = q8;
        for (int i = 1; i <= 6; i++) begin
            strobe(8'h04);
            chk(s8 == (i % 3 == 0), "R1 divide by 3", s8, (i % 3 == 0));
            if (i == 3) chk(q8 == ~sq0, "R8 square flips", q8, ~sq0);
            if (i == 4) chk(q8 == ~sq0, "R8 square holds between", q8, ~sq0);
        end
    endtask

    task automatic t_pass;
        wr(3'b100, 32'h0000_0000);
        for (int i = 0; i < 3; i++) begin
            strobe(8'h01);
            chk(s8, "R1 divide by 1 passes all", s8, 1);
        end
    endtask

    task automatic t_div64;
        wr(3'b100, 32'h0000_003F);
        for (int i = 1; i <= 64; i++) begin
            strobe(8'h01);
            if (i == 63) chk(!s8, "R1 no strobe at 63 of 64", s8, 0);
            if (i == 64) chk(s8, "R1 strobe at 64 of 64", s8, 1);
        end
    endtask

    task automatic t_boundary;
        wr(3'b100, 32'h0000_1003);
        strobe(8'h02);
        strobe(8'h02);
        chk(!s8, "R1 mid period quiet", s8, 0);
        wr(3'b100, 32'h0000_3000);
        strobe(8'h08);
        chk(!s8, "R6 new parent waits for boundary", s8, 0);
        strobe(8'h02);
        chk(!s8, "R6 old ratio third strobe", s8, 0);
        strobe(8'h02);
        chk(s8, "R6 old ratio completes period", s8, 1);
        strobe(8'h08);
        chk(s8, "R6 new parent and ratio applied", s8, 1);
        strobe(8'h02);
        chk(!s8, "R6 old parent now ignored", s8, 0);
    endtask

    task automatic t_stop;
        logic sq0;
        wr(3'b100, 32'h0000_0002);
        strobe(8'h01);
        strobe(8'h01);
        sq0 = q8;
        wr(3'b100, 32'h0000_0102);
        chk(rd8 == 32'h102, "R4 stop keeps field 2", rd8, 32'h102);
        for (int i = 0; i < 3; i++) begin
            strobe(8'h01);
            chk(!s8, "R2 stopped no strobe", s8, 0);
        end
        chk(q8 == sq0, "R2 square held while stopped", q8, sq0);
        wr(3'b100, 32'h0000_0002);
        strobe(8'h01);
        strobe(8'h01);
        chk(!s8, "R7 count restarted after stop", s8, 0);
        strobe(8'h01);
        chk(s8, "R7 first strobe after full period", s8, 1);
    endtask

    task automatic t_small;
        wr(3'b011, 32'h0000_0100);
        wr(3'b010, 32'h0000_0080);
        chk(rd4 == 32'h80, "R3 select at 7:6", rd4, 32'h80);
        strobe(8'h01);
        chk(!s4, "R3 4 parents unselected ignored", s4, 0);
        strobe(8'h04);
        chk(s4, "R3 4 parents selected passes", s4, 1);
        wr(3'b001, 32'h0000_70C0);
        chk(rd1 == 32'h0, "R5 no select field for 1 parent", rd1, 32'h0);
        strobe(8'h02);
        chk(!s1, "R3 1 parent ignores other inputs", s1, 0);
        strobe(8'h01);
        chk(s1, "R3 1 parent uses parent 0", s1, 1);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_divide3();
        t_pass();
        t_div64();
        t_boundary();
        t_stop();
        t_small();
        finish_run();
    end

endmodule